// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped cache. It keeps the lines that cache has recently thrown out. When the main cache misses, the block checks its own entries against the full line address. Every entry has its own comparator, so all entries are checked in the same cycle. A match means the line is still on chip. The main cache then takes the line back, and the line that the main cache gives up in exchange goes into the same slot.

When neither the main cache nor the buffer holds the line, the refill pushes a line out of the main cache, and that line is inserted here. If a slot is empty, the line goes into the lowest-numbered empty slot. If all slots are full, the line goes over the entry that has been in the buffer longest. A dirty bit travels with every line. An entry that leaves the buffer while dirty is shown on a write-back output in that same cycle, so the line can be written to the next level. A clean entry that leaves this way is simply dropped.

Lookup results, the swap data and the write-back data are combinational. They are valid in the cycle of the request, and the buffer contents update at the next rising clock edge.

Top module: `victim_buffer`

## Requirements
- R1: After reset, every entry is empty: a lookup reports no hit, and the first insert raises no write-back.
- R2: A lookup (`lk_valid`=1) of a resident line address asserts `lk_hit`. In the same cycle it drives that entry's slot number on `lk_idx`, its line on `swap_data` and its dirty bit on `swap_dirty`.
- R3: An insert into a buffer that has empty slots fills the lowest-numbered empty slot. Starting from reset, the first three inserts land in slots 0, 1 and 2.
- R4: A lookup that matches no entry, issued with no insert, reports `lk_hit`=0 and leaves the contents unchanged.
- R5: A lookup hit together with an insert (a swap) writes the inserted line, with its address and dirty bit, into the slot that hit. The swap never raises a write-back.
- R6: A lookup hit with no insert empties the hit slot. A later lookup of that address misses, and the next insert refills that slot if it is the lowest empty one.
- R7: An insert into a full buffer with no lookup hit replaces the entry that entered the buffer earliest (first-in, first-out).
- R8: When the entry pushed out by R7 is dirty, `wb_valid`=1 in that cycle, with the pushed-out line's address on `wb_addr` and its line on `wb_data`. When it is clean, `wb_valid` stays 0.
- R9: A line written by a swap counts as the newest entry when the buffer later picks an entry to replace.
- R10: With `lk_valid`=0, `lk_hit` is 0 even if `lk_addr` names a resident line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request, issued on a main-cache miss |
| lk_addr | input | ADDR_W | Line address being looked up |
| lk_hit | output | 1 | Lookup matched a resident entry; the line is being swapped out |
| lk_idx | output | IDX_W | Slot number of the matching entry |
| swap_data | output | LINE_W | Line returned to the main cache on a hit |
| swap_dirty | output | 1 | Dirty bit of the returned line |
| ins_valid | input | 1 | A line evicted from the main cache is offered for storage |
| ins_addr | input | ADDR_W | Line address of the evicted line |
| ins_data | input | LINE_W | Contents of the evicted line |
| ins_dirty | input | 1 | Dirty bit of the evicted line |
| wb_valid | output | 1 | A dirty entry is leaving the buffer and must be written back |
| wb_addr | output | ADDR_W | Line address of the written-back entry |
| wb_data | output | LINE_W | Contents of the written-back entry |

## Verification
The assertions assume that the caller never offers a line that is already resident in the buffer. They also assume that, during a swap, the inserted address differs from the address being looked up. Under those two conditions at most one comparator can match, and the slot-ordering ranks stay a permutation. The stimulus table keeps every address unique among resident lines: an address goes back in only after it has been swapped out or pushed out. The reset test likewise starts from an empty buffer.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_INSERT = 2'd1,
    VC_SWAP   = 2'd2,
    VC_DROP   = 2'd3
  } vc_op_e;
endpackage

// File: rtl/vc_store.sv
module vc_store #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int DW = 64,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_dirty,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  valid_o,
  output logic [N-1:0]  dirty_o,
  output logic [AW-1:0] tag_o  [N],
  output logic [DW-1:0] data_o [N]
);
  for (genvar i = 0; i < N; i++) begin : g_entry
    logic wr_here, clr_here;
    assign wr_here  = wr_en  && (wr_idx  == IW'(i));
    assign clr_here = clr_en && (clr_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[i] <= 1'b0;
        dirty_o[i] <= 1'b0;
        tag_o[i]   <= '0;
        data_o[i]  <= '0;
      end else if (wr_here) begin
        valid_o[i] <= 1'b1;
        dirty_o[i] <= wr_dirty;
        tag_o[i]   <= wr_addr;
        data_o[i]  <= wr_data;
      end else if (clr_here) begin
        valid_o[i] <= 1'b0;
        dirty_o[i] <= 1'b0;
      end
    end
  end

  // R6: an emptied slot reads as empty on the next cycle
  a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !valid_o[$past(clr_idx)]);
endmodule

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] key,
  input  logic [N-1:0]  valid,
  input  logic [AW-1:0] tags [N],
  output logic [N-1:0]  match_vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] encode(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) if (v[k]) r = IW'(k);
    return r;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_vec[i] = en && valid[i] && (tags[i] == key);
  end

  assign hit = |match_vec;
  assign idx = encode(match_vec);

  // R2: one address lives in at most one slot
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/vc_repl.sv
module vc_repl #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic          retire_en,
  input  logic [IW-1:0] retire_idx,
  output logic          full,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [IW-1:0] rank_q [N];
  logic [IW-1:0] free_idx, old_idx;
  logic [IW-1:0] touch_rank, retire_rank;

  function automatic logic [IW-1:0] lowest_free(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) if (!v[k]) r = IW'(k);
    return r;
  endfunction

  always_comb begin
    old_idx = '0;
    for (int k = 0; k < N; k++) if (rank_q[k] == OLDEST) old_idx = IW'(k);
  end

  assign full        = &valid;
  assign free_idx    = lowest_free(valid);
  assign victim_idx  = full ? old_idx : free_idx;
  assign touch_rank  = rank_q[touch_idx];
  assign retire_rank = rank_q[retire_idx];

  for (genvar i = 0; i < N; i++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[i] <= IW'(i);
      end else if (touch_en) begin
        if (touch_idx == IW'(i))          rank_q[i] <= '0;
        else if (rank_q[i] < touch_rank)  rank_q[i] <= rank_q[i] + 1'b1;
      end else if (retire_en) begin
        if (retire_idx == IW'(i))         rank_q[i] <= OLDEST;
        else if (rank_q[i] > retire_rank) rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  for (genvar v = 0; v < N; v++) begin : g_uniq
    logic [N-1:0] holds;
    for (genvar k = 0; k < N; k++) begin : g_eq
      assign holds[k] = (rank_q[k] == IW'(v));
    end
    // R7: age ranks stay a permutation, so exactly one oldest exists
    a_r7_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds));
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [LINE_W-1:0] swap_data,
  output logic              swap_dirty,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [LINE_W-1:0] ins_data,
  input  logic              ins_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  import vc_pkg::*;

  logic [ENTRIES-1:0] valid_w, dirty_w, match_w;
  logic [ADDR_W-1:0]  tag_w  [ENTRIES];
  logic [LINE_W-1:0]  data_w [ENTRIES];
  logic               full_w;
  logic [IDX_W-1:0]   victim_w, wr_idx_w;
  vc_op_e             op_w;
  logic               push_out_w;

  vc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .en(lk_valid), .key(lk_addr),
    .valid(valid_w), .tags(tag_w),
    .match_vec(match_w), .hit(lk_hit), .idx(lk_idx)
  );

  always_comb begin
    if (lk_hit && ins_valid)  op_w = VC_SWAP;
    else if (lk_hit)          op_w = VC_DROP;
    else if (ins_valid)       op_w = VC_INSERT;
    else                      op_w = VC_IDLE;
  end

  assign wr_idx_w   = (op_w == VC_SWAP) ? lk_idx : victim_w;
  assign push_out_w = (op_w == VC_INSERT) && full_w;

  vc_store #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W), .IW(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_valid), .wr_idx(wr_idx_w), .wr_addr(ins_addr),
    .wr_data(ins_data), .wr_dirty(ins_dirty),
    .clr_en(op_w == VC_DROP), .clr_idx(lk_idx),
    .valid_o(valid_w), .dirty_o(dirty_w), .tag_o(tag_w), .data_o(data_w)
  );

  vc_repl #(.N(ENTRIES), .IW(IDX_W)) u_repl (
    .clk(clk), .rst_n(rst_n), .valid(valid_w),
    .touch_en(ins_valid), .touch_idx(wr_idx_w),
    .retire_en(op_w == VC_DROP), .retire_idx(lk_idx),
    .full(full_w), .victim_idx(victim_w)
  );

  assign swap_data  = data_w[lk_idx];
  assign swap_dirty = dirty_w[lk_idx];
  assign wb_valid   = push_out_w && dirty_w[victim_w];
  assign wb_addr    = tag_w[victim_w];
  assign wb_data    = data_w[victim_w];

  // R5: the swapped-in line occupies the slot that hit
  a_r5_swap_lands_in_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == VC_SWAP) |=> (valid_w[$past(lk_idx)] && tag_w[$past(lk_idx)] == $past(ins_addr)));
  // R8: write-back only when a full buffer takes a fresh line
  a_r8_wb_needs_full_insert: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (ins_valid && !lk_hit && (&valid_w)));
  // R10: no hit without a lookup request
  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
  // R4: a cycle with neither hit nor insert leaves occupancy alone
  a_r4_miss_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit && !ins_valid) |=> $stable(valid_w));
endmodule

// File: tb/victim_buffer_tb.sv
`timescale 1ns/1ps
module victim_buffer_tb;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [1:0]    lk_idx;
  logic [DW-1:0] swap_data;
  logic          swap_dirty;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic          ins_dirty = 1'b0;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  victim_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .swap_data(swap_data), .swap_dirty(swap_dirty),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [DW-1:0] line_of(input int a);
    return {32'(a) ^ 32'h5A5A_0000, 32'(a) * 32'd3 + 32'd7};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    int lv; int la; int iv; int ia; int id;
    int eh; int ei; int ed; int ew; int ewa;
  } row_t;

  // lookup valid/addr, insert valid/addr/dirty, expected hit/idx/dirty, expected wb/addr
  localparam int NROWS = 20;
  localparam row_t TBL [NROWS] = '{
    '{1, 'h10, 0, 0,     0, 0, 0, 0, 0, 0},     // R1 R4 empty miss
    '{0, 0,    1, 'h10,  0, 0, 0, 0, 0, 0},     // R3 slot0
    '{0, 0,    1, 'h11,  1, 0, 0, 0, 0, 0},     // R3 slot1
    '{0, 0,    1, 'h12,  0, 0, 0, 0, 0, 0},     // R3 slot2
    '{1, 'h11, 0, 0,     0, 1, 1, 1, 0, 0},     // R2 R6 hit then drop
    '{1, 'h11, 0, 0,     0, 0, 0, 0, 0, 0},     // R6 dropped line misses
    '{0, 0,    1, 'h13,  1, 0, 0, 0, 0, 0},     // R6 refill slot1
    '{0, 0,    1, 'h14,  0, 0, 0, 0, 0, 0},     // fills slot3
    '{1, 'h12, 1, 'h20,  1, 1, 2, 0, 0, 0},     // R5 swap
    '{1, 'h20, 1, 'h21,  1, 1, 2, 1, 0, 0},     // R5 swapped line present
    '{1, 'h30, 1, 'h31,  0, 0, 0, 0, 0, 0},     // R7 R8 oldest 10 clean
    '{0, 0,    1, 'h32,  0, 0, 0, 0, 1, 'h13},  // R8 dirty 13 written back
    '{0, 0,    1, 'h33,  0, 0, 0, 0, 0, 0},     // R7 14 clean out
    '{1, 'h31, 1, 'h40,  1, 1, 0, 0, 0, 0},     // R5 swap slot0
    '{0, 0,    1, 'h41,  0, 0, 0, 0, 1, 'h21},  // R9 21 out before 40
    '{0, 0,    1, 'h42,  0, 0, 0, 0, 0, 0},     // R7 32 out
    '{0, 0,    1, 'h43,  0, 0, 0, 0, 0, 0},     // R9 33 out, 40 kept
    '{0, 0,    1, 'h44,  0, 0, 0, 0, 1, 'h40},  // R9 40 out now
    '{0, 'h41, 0, 0,     0, 0, 0, 0, 0, 0},     // R10 no request
    '{1, 'h41, 1, 'h50,  0, 1, 2, 0, 0, 0}      // R2 41 still present
  };

  task automatic drive_row(input row_t r);
    lk_valid  = (r.lv != 0);
    lk_addr   = AW'(r.la);
    ins_valid = (r.iv != 0);
    ins_addr  = AW'(r.ia);
    ins_data  = line_of(r.ia);
    ins_dirty = (r.id != 0);
  endtask

  task automatic idle_inputs();
    lk_valid = 1'b0; ins_valid = 1'b0; lk_addr = '0; ins_addr = '0; ins_data = '0; ins_dirty = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    lk_valid = 1'b1; lk_addr = AW'('h10); #1;
    chk("R1", "hit after reset", 64'(lk_hit), 64'd0);
    chk("R1", "wb after reset", 64'(wb_valid), 64'd0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive_row(TBL[i]);
      #1;
      chk($sformatf("R2/R5 row%0d", i), "lk_hit", 64'(lk_hit), 64'(TBL[i].eh));
      if (TBL[i].eh != 0) begin
        chk($sformatf("R2 row%0d", i), "lk_idx", 64'(lk_idx), 64'(TBL[i].ei));
        chk($sformatf("R2 row%0d", i), "swap_dirty", 64'(swap_dirty), 64'(TBL[i].ed));
        chk($sformatf("R2 row%0d", i), "swap_data", swap_data, line_of(TBL[i].la));
      end
      chk($sformatf("R8 row%0d", i), "wb_valid", 64'(wb_valid), 64'(TBL[i].ew));
      if (TBL[i].ew != 0) begin
        chk($sformatf("R8 row%0d", i), "wb_addr", 64'(wb_addr), 64'(TBL[i].ewa));
        chk($sformatf("R8 row%0d", i), "wb_data", wb_data, line_of(TBL[i].ewa));
      end
    end

    // R1 reset with a full buffer empties it
    @(negedge clk); idle_inputs(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    lk_valid = 1'b1; lk_addr = AW'('h44); #1;
    chk("R1", "hit after second reset", 64'(lk_hit), 64'd0);
    @(negedge clk); idle_inputs();
    ins_valid = 1'b1; ins_addr = AW'('h60); ins_data = line_of('h60); ins_dirty = 1'b1; #1;
    chk("R1", "wb on first insert", 64'(wb_valid), 64'd0);
    @(negedge clk); idle_inputs();
    lk_valid = 1'b1; lk_addr = AW'('h60); ins_valid = 1'b1; ins_addr = AW'('h61);
    ins_data = line_of('h61); #1;
    chk("R3", "first insert in slot0", 64'(lk_idx), 64'd0);
    chk("R2", "dirty kept", 64'(swap_dirty), 64'd1);

    @(negedge clk); idle_inputs();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule